// File: doc/BRIEF.md
# Core power bring-up sequencer

A hardware state machine that brings a secondary processor core out of power gating and releases it from reset. After a start request with a core index, it reads a shared core-control register to find out whether the core is already running. If it is not, it goes through that core's power-control register in a fixed order: switch enable, power good, clamp release, memory power-down clear, memory switch enable, memory power good, memory clamp release. At the end it sets the core's active-low reset bit in the core-control register.

Every register access goes through a single request/acknowledge port. Steps that wait on hardware re-read the power-control register until the status field they watch reads as expected. A programmable cycle limit ends a stalled wait with an error. The sequencer reports the outcome as a one-cycle pulse: done, already-on or error.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the block is idle: `reg_req_o`, `busy_o`, `done_o`, `already_on_o` and `err_o` are all low.
- R2: A start with a core index of `NUM_CORES` (2) or more raises `err_o` in the next cycle and makes no register access.
- R3: The first access is a read of the core-control register at 0x30. If bit 13 plus the core index is set, `already_on_o` pulses and no write is made.
- R4: Next, the power-control register at 0x34 + 4 × index is read. The read value with bits 21:20 set to 0b11 is then written back, and the register is re-read until bits 29:28 read 0b11.
- R5: The shadow with bits 17:16 also set is then written, and the register is re-read until bits 25:24 read 0b11.
- R6: Next comes a write with bit 15 cleared, then a write with bits 11:8 also cleared.
- R7: Next comes a write with bit 1 set, with re-reads until bit 5 reads 1. Then a write with bit 0 set, with re-reads until bit 4 reads 1. Then a write with bit 2 cleared. Each write carries all earlier changes.
- R8: Finally, the core-control value captured by the first read, with bit 13 plus the index set, is written to 0x30, and `done_o` pulses in the cycle after that write is acknowledged.
- R9: `reg_req_o` stays high, with address, write enable and write data stable, until `reg_ack_i` is seen. The request drops in the cycle after the acknowledge.
- R10: A wait re-read that misses its expected value once at least `timeout_i` cycles have passed in that wait ends the sequence with `err_o`. After that there are no more writes and the reset bit is not written. A re-read that matches passes even with a limit of 0.
- R11: A start request while `busy_o` is high is ignored. It makes no extra accesses and no extra outcome pulse.
- R12: Each accepted start yields exactly one single-cycle pulse on one of `done_o`, `already_on_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up (sampled while idle) |
| core_idx_i | input | IDX_W | Core to bring up |
| timeout_i | input | TO_W | Cycle limit for each status wait |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | AW | Register offset |
| reg_wdata_o | output | DW | Write data |
| reg_ack_i | input | 1 | Access complete; read data valid |
| reg_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Pulse: core powered and released |
| already_on_o | output | 1 | Pulse: core was already out of reset |
| err_o | output | 1 | Pulse: bad index or wait timeout |

## Verification
The bench builds the block with its default parameters: two cores, a two-bit index that can also carry the invalid values 2 and 3, and a 16-bit wait limit. The limit is set to 20 cycles, or to 0 for the boundary cases. A register model behind the port makes status fields follow their request bits only after a chosen number of re-reads, and it can hold any one of the four status fields stuck at zero. This lets the bench sweep both cores, re-read lags 0 to 3, a stall in each wait, the zero limit, the already-on and invalid-index starts, and a start issued mid-sequence. Each written word is compared with a shadow built cumulatively in the bench.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_CTRL, ST_RD_PWR, ST_PON, ST_POK, ST_CLAMP,
    ST_PDA, ST_MON, ST_MOK, ST_MCLAMP, ST_RESET
  } step_e;

  localparam int unsigned CTRL_OFS   = 'h30;
  localparam int unsigned PWR_OFS    = 'h34;
  localparam int unsigned PWR_STRIDE = 4;
  localparam int unsigned RST_LSB    = 13;

  localparam int unsigned PON_REQ_LSB = 20;
  localparam int unsigned PON_ST_LSB  = 28;
  localparam int unsigned POK_REQ_LSB = 16;
  localparam int unsigned POK_ST_LSB  = 24;
  localparam int unsigned CLAMP_BIT   = 15;
  localparam int unsigned PDA_LSB     = 8;
  localparam int unsigned PDA_W       = 4;
  localparam int unsigned MEM_PON_BIT = 1;
  localparam int unsigned MEM_POK_BIT = 0;
  localparam int unsigned MEM_PON_ST  = 5;
  localparam int unsigned MEM_POK_ST  = 4;
  localparam int unsigned MEM_CLAMP   = 2;
endpackage

// File: rtl/pwr_seq_port.sv
module pwr_seq_port #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q  <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end else if (ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign req_o   = busy_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign busy_o  = busy_q;
  assign done_o  = busy_q & ack_i;
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned TO_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] core_idx_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic             reg_req_o,
  output logic             reg_we_o,
  output logic [AW-1:0]    reg_addr_o,
  output logic [DW-1:0]    reg_wdata_o,
  input  logic             reg_ack_i,
  input  logic [DW-1:0]    reg_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             already_on_o,
  output logic             err_o
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFS);
  localparam logic [AW-1:0] PWR_A  = AW'(PWR_OFS);
  localparam logic [AW-1:0] STRD_A = AW'(PWR_STRIDE);

  step_e            state_q;
  logic             polling_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    ctrl_q, val_q, wr_val;
  logic             done_q, aon_q, err_q;

  logic             acc_go, acc_we, port_busy, port_done, needs_poll, poll_ok, tmo_hit;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    rst_mask;

  assign rst_mask = DW'(1) << (RST_LSB + int'(idx_q));

  // next shadow value written by the current step
  always_comb begin
    wr_val = val_q;
    unique case (state_q)
      ST_PON:    wr_val = val_q | (DW'(3) << PON_REQ_LSB);
      ST_POK:    wr_val = val_q | (DW'(3) << POK_REQ_LSB);
      ST_CLAMP:  wr_val = val_q & ~(DW'(1) << CLAMP_BIT);
      ST_PDA:    wr_val = val_q & ~(DW'((1 << PDA_W) - 1) << PDA_LSB);
      ST_MON:    wr_val = val_q | (DW'(1) << MEM_PON_BIT);
      ST_MOK:    wr_val = val_q | (DW'(1) << MEM_POK_BIT);
      ST_MCLAMP: wr_val = val_q & ~(DW'(1) << MEM_CLAMP);
      ST_RESET:  wr_val = ctrl_q | rst_mask;
      default:   wr_val = val_q;
    endcase
  end

  always_comb begin
    needs_poll = 1'b0;
    poll_ok    = 1'b0;
    unique case (state_q)
      ST_PON: begin needs_poll = 1'b1; poll_ok = &reg_rdata_i[PON_ST_LSB +: 2]; end
      ST_POK: begin needs_poll = 1'b1; poll_ok = &reg_rdata_i[POK_ST_LSB +: 2]; end
      ST_MON: begin needs_poll = 1'b1; poll_ok = reg_rdata_i[MEM_PON_ST]; end
      ST_MOK: begin needs_poll = 1'b1; poll_ok = reg_rdata_i[MEM_POK_ST]; end
      default: ;
    endcase
  end

  assign acc_we   = !polling_q && !(state_q inside {ST_IDLE, ST_RD_CTRL, ST_RD_PWR});
  assign acc_addr = (state_q inside {ST_RD_CTRL, ST_RESET}) ? CTRL_A
                                                            : PWR_A + AW'(idx_q) * STRD_A;
  assign acc_go   = (state_q != ST_IDLE) && !port_busy;

  pwr_seq_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (acc_go),
    .we_i    (acc_we),
    .addr_i  (acc_addr),
    .wdata_i (wr_val),
    .req_o   (reg_req_o),
    .we_o    (reg_we_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .ack_i   (reg_ack_i),
    .busy_o  (port_busy),
    .done_o  (port_done)
  );

  pwr_seq_timer #(.W(TO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (port_done && !polling_q),
    .en_i      (polling_q),
    .limit_i   (timeout_i),
    .expired_o (tmo_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      polling_q <= 1'b0;
      idx_q     <= '0;
      ctrl_q    <= '0;
      val_q     <= '0;
      done_q    <= 1'b0;
      aon_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      aon_q  <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          if (int'(core_idx_i) >= NUM_CORES) err_q <= 1'b1;
          else begin
            idx_q   <= core_idx_i;
            state_q <= ST_RD_CTRL;
          end
        end
      end else if (port_done) begin
        unique case (state_q)
          ST_RD_CTRL: begin
            ctrl_q <= reg_rdata_i;
            if (reg_rdata_i[RST_LSB + int'(idx_q)]) begin
              aon_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else state_q <= ST_RD_PWR;
          end
          ST_RD_PWR: begin
            val_q   <= reg_rdata_i;
            state_q <= ST_PON;
          end
          default: begin
            if (!polling_q) begin
              val_q <= wr_val;
              if (needs_poll) polling_q <= 1'b1;
              else if (state_q == ST_RESET) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else state_q <= step_e'(state_q + 4'd1);
            end else if (poll_ok) begin
              polling_q <= 1'b0;
              state_q   <= step_e'(state_q + 4'd1);
            end else if (tmo_hit) begin
              polling_q <= 1'b0;
              err_q     <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign already_on_o = aon_q;
  assign err_o        = err_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned TO_W      = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [IDX_W-1:0] core_idx_i,
  input logic             reg_req_o,
  input logic             reg_we_o,
  input logic [AW-1:0]    reg_addr_o,
  input logic [DW-1:0]    reg_wdata_o,
  input logic             reg_ack_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             already_on_o,
  input logic             err_o
);
  localparam logic [AW-1:0] CTRL_A = AW'('h30);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o)
                                && $stable(reg_wdata_o));

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i |=> !reg_req_o);

  // R12
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, already_on_o, err_o}));

  // R8
  done_after_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(reg_req_o && reg_ack_i && reg_we_o && reg_addr_o == CTRL_A));

  // R2
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (int'(core_idx_i) >= NUM_CORES) |=> err_o && !reg_req_o && !busy_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !reg_req_o);
endmodule

bind core_pwr_seq pwr_seq_chk #(
  .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .AW(AW), .DW(DW), .TO_W(TO_W)
) u_chk (.*);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PWR_INIT = 32'h0040_8F04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  core_idx = '0;
  logic [15:0] timeout = 16'd20;
  logic        reg_req, reg_we, reg_ack;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        busy, done, aon, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .core_idx_i(core_idx),
    .timeout_i(timeout), .reg_req_o(reg_req), .reg_we_o(reg_we),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_ack_i(reg_ack),
    .reg_rdata_i(reg_rdata), .busy_o(busy), .done_o(done),
    .already_on_o(aon), .err_o(err)
  );

  // register model
  logic [31:0] m_ctrl = '0, m_pwr0 = '0, m_pwr1 = '0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_ctrl = '0;
  int          lag = 0, stuck = 0, reads_since = 0;
  logic [7:0]  wlog_a [0:1023];
  logic [31:0] wlog_d [0:1023];
  int          nw = 0, nr = 0, n_done = 0, n_aon = 0, n_err = 0, viol = 0;
  logic        req_d = 1'b0, ack_d = 1'b0;
  logic [7:0]  addr_d = '0;
  int          nchk = 0, nfail = 0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) reg_ack <= 1'b0;
    else        reg_ack <= reg_req && !reg_ack;

  always_comb begin : model_rd
    logic [31:0] v;
    logic ok;
    ok = (reads_since >= lag);
    if (reg_addr == 8'h30) reg_rdata = m_ctrl;
    else begin
      v = (reg_addr == 8'h34) ? m_pwr0 : m_pwr1;
      v[29:28] = (ok && stuck != 1) ? v[21:20] : 2'b00;
      v[25:24] = (ok && stuck != 2) ? v[17:16] : 2'b00;
      v[5]     = ok && stuck != 3 && v[1];
      v[4]     = ok && stuck != 4 && v[0];
      reg_rdata = v;
    end
  end

  always @(posedge clk) begin
    if (ld_en) begin
      m_ctrl <= ld_ctrl;
      m_pwr0 <= PWR_INIT;
      m_pwr1 <= PWR_INIT;
    end else if (reg_req && reg_ack) begin
      if (reg_we) begin
        wlog_a[nw] <= reg_addr;
        wlog_d[nw] <= reg_wdata;
        nw <= nw + 1;
        reads_since <= 0;
        if (reg_addr == 8'h30) m_ctrl <= reg_wdata;
        else if (reg_addr == 8'h34) m_pwr0 <= reg_wdata;
        else if (reg_addr == 8'h38) m_pwr1 <= reg_wdata;
      end else begin
        nr <= nr + 1;
        reads_since <= reads_since + 1;
      end
    end
    if (done) n_done <= n_done + 1;
    if (aon)  n_aon  <= n_aon + 1;
    if (err)  n_err  <= n_err + 1;
    if (req_d && !ack_d && (!reg_req || reg_addr != addr_d)) viol <= viol + 1;
    req_d  <= reg_req;
    ack_d  <= reg_ack;
    addr_d <= reg_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_write(input int k, input int idx, input logic [31:0] ci);
    logic [31:0] v;
    v = PWR_INIT;
    for (int j = 0; j <= k && j < 7; j++) begin
      case (j)
        0: v = v | 32'h0030_0000;
        1: v = v | 32'h0003_0000;
        2: v = v & ~32'h0000_8000;
        3: v = v & ~32'h0000_0F00;
        4: v = v | 32'h2;
        5: v = v | 32'h1;
        default: v = v & ~32'h4;
      endcase
    end
    if (k == 7) return {8'h30, ci | (32'h1 << (13 + idx))};
    return {8'(8'h34 + 4 * idx), v};
  endfunction

  function automatic string step_req(input int k);
    case (k)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      7: return "R8";
      default: return "R7";
    endcase
  endfunction

  // kind: 0 done, 1 already on, 2 error
  task automatic run(input int idx, input int lag_v, input int stuck_v, input int tmo,
                     input logic [31:0] ci, input int kind, input int exp_w, input bit dup);
    int bw, br, bd, ba, be, cyc;
    @(negedge clk);
    lag = lag_v; stuck = stuck_v; timeout = 16'(tmo);
    ld_ctrl = ci; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    bw = nw; br = nr; bd = n_done; ba = n_aon; be = n_err;
    start = 1'b1; core_idx = 2'(idx);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (n_done + n_aon + n_err == bd + ba + be && cyc < 3000) begin
      if (dup && cyc == 10) begin start = 1'b1; core_idx = 2'(idx ^ 1); end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    repeat (2) @(negedge clk);
    // R12
    chk((n_done - bd) == (kind == 0) && (n_aon - ba) == (kind == 1) && (n_err - be) == (kind == 2),
        kind == 1 ? "R3" : (kind == 2 ? "R10" : "R12"),
        32'((n_done - bd) * 256 + (n_aon - ba) * 16 + (n_err - be)),
        32'((kind == 0) * 256 + (kind == 1) * 16 + (kind == 2)));
    chk(nw - bw == exp_w, kind == 1 ? "R3" : "R10", 32'(nw - bw), 32'(exp_w));
    for (int k = 0; k < exp_w && k < nw - bw; k++) begin
      logic [39:0] e;
      e = exp_write(k, idx, ci);
      chk({wlog_a[bw + k], wlog_d[bw + k]} == e, step_req(k),
          wlog_d[bw + k], e[31:0]);
    end
    if (idx >= 2) chk(nr == br && nw == bw, "R2", 32'(nr - br + nw - bw), 32'h0);
    if (kind != 0) chk(m_ctrl == ci, "R10", m_ctrl, ci);
    if (dup) begin
      repeat (40) @(negedge clk);
      // R11
      chk(nw - bw == exp_w && n_done - bd == 1 && !busy, "R11", 32'(nw - bw), 32'(exp_w));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!reg_req && !busy && !done && !aon && !err, "R1",
        {27'h0, reg_req, busy, done, aon, err}, 32'h0);

    for (int idx = 0; idx < 2; idx++)
      for (int l = 0; l < 4; l++)
        run(idx, l, 0, 20, (idx == 0) ? 32'h0000_4003 : 32'h0000_2003, 0, 8, 1'b0);
    // R3: already on
    for (int idx = 0; idx < 2; idx++)
      run(idx, 0, 0, 20, 32'h0000_6001, 1, 0, 1'b0);
    // R2: invalid index
    for (int idx = 2; idx < 4; idx++)
      run(idx, 0, 0, 20, 32'h0, 2, 0, 1'b0);
    // R10: each wait stalled
    for (int idx = 0; idx < 2; idx++)
      for (int s = 1; s <= 4; s++)
        run(idx, 1, s, 20, 32'h0000_0010, 2, (s <= 2) ? s : s + 2, 1'b0);
    // R10: zero limit boundary
    run(1, 0, 0, 0, 32'h0, 0, 8, 1'b0);
    run(0, 1, 0, 0, 32'h0, 2, 1, 1'b0);
    // R11: start while busy
    run(0, 2, 0, 20, 32'h0, 0, 8, 1'b1);
    // R9
    chk(viol == 0, "R9", 32'(viol), 32'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R12 watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule